// File: doc/BRIEF.md
# Multi-Operand Computation Unit Controller

This block is the control core of a scoreboard computation unit whose operations take up to three source operands and produce up to two results. Each source operand has its own read request and go-read acknowledge, and each result has its own write request and go-write acknowledge. A unit can therefore make progress when register-file ports become free one at a time, instead of waiting for every port in the same cycle.

An issue pulse carries two enable masks: one for the operands the operation needs and one for the results it produces. Operands and results that are not enabled count as already complete. Go-read acknowledges can arrive in any order, in any combination, or all together. Write requests open only after every needed operand has been captured. The unit goes idle again only once every needed result has been acknowledged.

A registered read-release flag tells the picker that acknowledges have been taken. This keeps the go-read feedback loop behind a clock edge. The arithmetic is a simple placeholder: the sum of the captured operands and the carry out of that sum.

Top module: `opcu_ctrl`

## Requirements
- R1: After reset, busy, every read request, every write request and the read-release flag are low.
- R2: An issue seen while idle sets busy at the next clock edge. From then on, read request bit i is high exactly for the operands whose bit i was set in the read-enable mask.
- R3: A go-read on lane i while read request i is high captures data lane i (bits i*DATA_W upward) at that edge. It clears request i from the next cycle and leaves the other read requests unchanged.
- R4: A go-read or go-write whose matching request is low is ignored. The requests and the results do not change because of it.
- R5: Write requests are all low while any read request is high. Once no read is pending, write request j is high exactly for the enabled results not yet acknowledged.
- R6: A go-write on lane j while write request j is high clears only request j from the next cycle.
- R7: Busy falls at the edge where no read is pending and the last pending write is accepted, or no write was enabled. It never falls while a read is still pending.
- R8: An issue seen while busy is ignored. Busy, the requests and the captured operands are unchanged.
- R9: While any write request is high, result 0 is the sum of the captured operands modulo 2^DATA_W. Result 1 is the part of that sum above DATA_W bits, zero-extended. An operand that is not enabled counts as zero.
- R10: The read-release flag rises the cycle after any accepted go-read. It falls after an edge at which busy is low and every go-read line is low. Otherwise it holds its value.
- R11: An issue with an empty read mask raises the enabled write requests in the first busy cycle. An issue with both masks empty keeps busy high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue pulse |
| rd_need_i | input | N_RD | Operand enable mask, sampled with issue |
| wr_need_i | input | N_WR | Result enable mask, sampled with issue |
| rd_go_i | input | N_RD | Go-read acknowledge per operand |
| rd_data_i | input | N_RD*DATA_W | Operand data, lane i at bits i*DATA_W upward |
| wr_go_i | input | N_WR | Go-write acknowledge per result |
| busy_o | output | 1 | Unit holds an operation |
| rd_req_o | output | N_RD | Read request per operand |
| wr_req_o | output | N_WR | Write request per result |
| rd_rel_o | output | 1 | Read-release flag |
| res_o | output | N_WR*DATA_W | Result data, lane j at bits j*DATA_W upward |

## Verification
The bench builds the block with DATA_W=8, three operands and two results. The narrow width makes every carry value from 0 to 2 occur often under random operand data. With three read lanes and two write lanes, each 1/2 probability go pattern reaches every ordering of acknowledges: single ones, pairs and all-at-once. It also reaches frequent go pulses on lanes with no request. Directed sequences cover empty masks, an issue while busy and a go-read held across the return to idle, which releases the read-release flag.

// File: rtl/opcu_pkg.sv
package opcu_pkg;
   // width of an exact sum of n operands of w bits each
   function automatic int sum_width(input int n, input int w);
      return w + ((n > 1) ? $clog2(n) : 0);
   endfunction
endpackage

// File: rtl/opcu_rd_lane.sv
module opcu_rd_lane #(
   parameter int DATA_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              arm_i,
   input  logic              need_i,
   input  logic              busy_i,
   input  logic              go_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              req_o,
   output logic              done_o,
   output logic              take_o,
   output logic [DATA_W-1:0] opnd_o
);
   logic pend_q;

   assign req_o  = pend_q & busy_i;
   assign take_o = go_i & req_o;
   assign done_o = ~pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
         opnd_o <= '0;
      end else if (arm_i) begin
         pend_q <= need_i;
         opnd_o <= '0;
      end else if (take_o) begin
         pend_q <= 1'b0;
         opnd_o <= data_i;
      end
   end

   AST_RD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && go_i) |=> !req_o); // R3
   AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !go_i) |=> req_o); // R3
   AST_RD_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_o && !arm_i) |=> $stable(opnd_o)); // R4
endmodule

// File: rtl/opcu_wr_lane.sv
module opcu_wr_lane (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic need_i,
   input  logic open_i,
   input  logic go_i,
   output logic req_o,
   output logic left_o
);
   logic pend_q;
   logic take;

   assign req_o  = pend_q & open_i;
   assign take   = go_i & req_o;
   assign left_o = pend_q & ~take;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q <= 1'b0;
      else if (arm_i)  pend_q <= need_i;
      else if (take)   pend_q <= 1'b0;
   end

   AST_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && go_i) |=> !req_o); // R6
   AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !go_i) |=> req_o); // R6
endmodule

// File: rtl/opcu_compute.sv
module opcu_compute #(
   parameter int N_RD   = 3,
   parameter int N_WR   = 2,
   parameter int DATA_W = 16
) (
   input  logic [N_RD*DATA_W-1:0] opnd_i,
   output logic [N_WR*DATA_W-1:0] res_o
);
   import opcu_pkg::*;
   localparam int SUM_W = sum_width(N_RD, DATA_W);
   localparam int CY_W  = SUM_W - DATA_W;

   logic [SUM_W-1:0]  total;
   logic [DATA_W-1:0] parity;

   always_comb begin
      total  = '0;
      parity = '0;
      for (int i = 0; i < N_RD; i++) begin
         total  = total + SUM_W'(opnd_i[i*DATA_W +: DATA_W]);
         parity = parity ^ opnd_i[i*DATA_W +: DATA_W];
      end
   end

   for (genvar j = 0; j < N_WR; j++) begin : g_res
      if (j == 0) begin : g_sum
         assign res_o[j*DATA_W +: DATA_W] = total[DATA_W-1:0];
      end else if (j == 1) begin : g_carry
         if (CY_W == 0) begin : g_nocy
            assign res_o[j*DATA_W +: DATA_W] = '0;
         end else begin : g_cy
            assign res_o[j*DATA_W +: DATA_W] = DATA_W'(total[SUM_W-1:DATA_W]);
         end
      end else begin : g_xor
         assign res_o[j*DATA_W +: DATA_W] = parity;
      end
   end
endmodule

// File: rtl/opcu_ctrl.sv
module opcu_ctrl #(
   parameter int DATA_W = 16,
   parameter int N_RD   = 3,
   parameter int N_WR   = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     issue_i,
   input  logic [N_RD-1:0]          rd_need_i,
   input  logic [N_WR-1:0]          wr_need_i,
   input  logic [N_RD-1:0]          rd_go_i,
   input  logic [N_RD*DATA_W-1:0]   rd_data_i,
   input  logic [N_WR-1:0]          wr_go_i,
   output logic                     busy_o,
   output logic [N_RD-1:0]          rd_req_o,
   output logic [N_WR-1:0]          wr_req_o,
   output logic                     rd_rel_o,
   output logic [N_WR*DATA_W-1:0]   res_o
);
   import opcu_pkg::*;
   localparam int CY_W = sum_width(N_RD, DATA_W) - DATA_W;

   if (DATA_W < 1 || N_RD < 1 || N_WR < 1) begin : g_bad_size
      $error("opcu_ctrl: DATA_W, N_RD and N_WR must be positive");
   end
   if (CY_W > DATA_W) begin : g_bad_carry
      $error("opcu_ctrl: carry does not fit in one result lane");
   end

   logic                   busy_q, rel_q;
   logic                   arm;
   logic                   reads_done, writes_clear;
   logic [N_RD-1:0]        rd_done, rd_take;
   logic [N_WR-1:0]        wr_left;
   logic [N_RD*DATA_W-1:0] opnd;

   assign arm = issue_i & ~busy_q;

   for (genvar i = 0; i < N_RD; i++) begin : g_rd
      opcu_rd_lane #(.DATA_W(DATA_W)) u_lane (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .arm_i  (arm),
         .need_i (rd_need_i[i]),
         .busy_i (busy_q),
         .go_i   (rd_go_i[i]),
         .data_i (rd_data_i[i*DATA_W +: DATA_W]),
         .req_o  (rd_req_o[i]),
         .done_o (rd_done[i]),
         .take_o (rd_take[i]),
         .opnd_o (opnd[i*DATA_W +: DATA_W])
      );
   end

   assign reads_done = &rd_done;

   for (genvar j = 0; j < N_WR; j++) begin : g_wr
      opcu_wr_lane u_lane (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .arm_i  (arm),
         .need_i (wr_need_i[j]),
         .open_i (busy_q & reads_done),
         .go_i   (wr_go_i[j]),
         .req_o  (wr_req_o[j]),
         .left_o (wr_left[j])
      );
   end

   assign writes_clear = ~|wr_left;

   opcu_compute #(.N_RD(N_RD), .N_WR(N_WR), .DATA_W(DATA_W)) u_calc (
      .opnd_i (opnd),
      .res_o  (res_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         if (arm)                                         busy_q <= 1'b1;
         else if (busy_q && reads_done && writes_clear)   busy_q <= 1'b0;
         if (|rd_take)                                    rel_q  <= 1'b1;
         else if (!busy_q && !(|rd_go_i))                 rel_q  <= 1'b0;
      end
   end

   assign busy_o   = busy_q;
   assign rd_rel_o = rel_q;

   AST_WR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|wr_req_o) |-> (rd_req_o == '0)); // R5
   AST_BUSY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (rd_req_o == '0 && wr_req_o == '0)); // R7
   AST_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && issue_i && (|rd_req_o)) |=> busy_o); // R8
   AST_REL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(rd_go_i & rd_req_o)) |=> rd_rel_o); // R10
   AST_REL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && rd_go_i == '0) |=> !rd_rel_o); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (rd_req_o == '0 && wr_req_o == '0)); // R2
endmodule

// File: tb/tb_opcu_ctrl.sv
module tb_opcu_ctrl;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue = 1'b0;
   logic [2:0]   rneed = '0, rgo = '0;
   logic [1:0]   wneed = '0, wgo = '0;
   logic [3*W-1:0] rdata = '0;
   logic         busy, rel;
   logic [2:0]   rreq;
   logic [1:0]   wreq;
   logic [2*W-1:0] res;

   int total = 0, bad = 0;
   bit finished = 0;

   // reference state
   logic       m_busy = 0, m_rel = 0;
   logic [2:0] m_rp = 0;
   logic [1:0] m_wp = 0;
   logic [W-1:0] m_op [3];

   always #2 clk = ~clk;

   opcu_ctrl #(.DATA_W(W), .N_RD(3), .N_WR(2)) dut (
      .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .rd_need_i(rneed),
      .wr_need_i(wneed), .rd_go_i(rgo), .rd_data_i(rdata), .wr_go_i(wgo),
      .busy_o(busy), .rd_req_o(rreq), .wr_req_o(wreq), .rd_rel_o(rel),
      .res_o(res));

   function automatic logic [2:0] exp_rreq();
      return m_busy ? m_rp : 3'b000;
   endfunction
   function automatic logic [1:0] exp_wreq();
      return (m_busy && m_rp == 0) ? m_wp : 2'b00;
   endfunction
   function automatic logic [2*W-1:0] exp_res();
      logic [W+1:0] s;
      s = (W+2)'(m_op[0]) + (W+2)'(m_op[1]) + (W+2)'(m_op[2]);
      return {W'(s[W+1:W]), s[W-1:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(busy == m_busy, tag, "busy (R7)", busy, m_busy);
      chk(rreq == exp_rreq(), tag, "rd_req (R3)", rreq, exp_rreq());
      chk(wreq == exp_wreq(), tag, "wr_req (R5)", wreq, exp_wreq());
      chk(rel == m_rel, tag, "rd_rel (R10)", rel, m_rel);
      if (exp_wreq() != 0)
         chk(res == exp_res(), tag, "result (R9)", res, exp_res());
   endtask

   task automatic step(input logic iss, input logic [2:0] rm, input logic [1:0] wm,
                       input logic [2:0] gr, input logic [1:0] gw,
                       input logic [3*W-1:0] d, input string tag);
      logic [2:0] acc_r, n_rp;
      logic [1:0] acc_w, n_wp;
      logic       n_busy, n_rel;
      logic [W-1:0] n_op [3];
      @(negedge clk);
      compare(tag);
      issue = iss; rneed = rm; wneed = wm; rgo = gr; wgo = gw; rdata = d;
      acc_r = gr & exp_rreq();
      acc_w = gw & exp_wreq();
      n_busy = m_busy; n_rp = m_rp; n_wp = m_wp;
      for (int i = 0; i < 3; i++) n_op[i] = m_op[i];
      if (iss && !m_busy) begin
         n_busy = 1; n_rp = rm; n_wp = wm;
         for (int i = 0; i < 3; i++) n_op[i] = '0;
      end else begin
         n_rp = m_rp & ~acc_r;
         n_wp = m_wp & ~acc_w;
         for (int i = 0; i < 3; i++) if (acc_r[i]) n_op[i] = d[i*W +: W];
         if (m_busy && m_rp == 0 && n_wp == 0) n_busy = 0;
      end
      if (acc_r != 0) n_rel = 1;
      else if (!m_busy && gr == 0) n_rel = 0;
      else n_rel = m_rel;
      @(posedge clk);
      #1;
      m_busy = n_busy; m_rp = n_rp; m_wp = n_wp; m_rel = n_rel;
      for (int i = 0; i < 3; i++) m_op[i] = n_op[i];
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < 3; i++) m_op[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(busy == 0 && rreq == 0 && wreq == 0 && rel == 0, "R1", "reset outputs",
          {busy, rreq, wreq, rel}, 0);
      rst_n = 1'b1;

      // R2: issue needing operands 0 and 2, both results
      step(1, 3'b101, 2'b11, 0, 0, 0, "R2");
      chk(busy == 1 && rreq == 3'b101, "R2", "after issue", {busy, rreq}, 4'b1101);
      // R4: go-read on an unrequested lane, go-write while gated
      step(0, 0, 0, 3'b010, 2'b11, 24'h00ff00, "R4");
      chk(rreq == 3'b101 && wreq == 0, "R4", "ignored go", {rreq, wreq}, 5'b10100);
      // R8: issue while busy with other masks
      step(1, 3'b010, 2'b00, 0, 0, 0, "R8");
      chk(rreq == 3'b101, "R8", "issue while busy", rreq, 3'b101);
      // R3: operand 2 alone, then operand 0
      step(0, 0, 0, 3'b100, 0, 24'hc8_0000, "R3");
      step(0, 0, 0, 3'b001, 0, 24'h0000_9a, "R3");
      // R9 + R6: result checks, then one write at a time
      step(0, 0, 0, 0, 2'b10, 0, "R6");
      chk(wreq == 2'b01 && res[W-1:0] == 8'h62, "R6", "one write left", {wreq, res[W-1:0]}, {2'b01, 8'h62});
      step(0, 0, 0, 0, 2'b01, 0, "R7");
      chk(busy == 0, "R7", "idle after last write", busy, 0);
      // R11: empty read mask opens writes at once
      step(1, 3'b000, 2'b01, 0, 0, 0, "R11");
      chk(busy == 1 && wreq == 2'b01, "R11", "writes open", {busy, wreq}, 3'b101);
      step(0, 0, 0, 0, 2'b01, 0, "R11");
      // R11: both masks empty, busy one cycle only
      step(1, 0, 0, 0, 0, 0, "R11");
      chk(busy == 1, "R11", "busy one cycle", busy, 1);
      step(0, 0, 0, 0, 0, 0, "R11");
      chk(busy == 0, "R11", "busy dropped", busy, 0);
      // all three reads in one cycle, go-read held past idle for R10
      step(1, 3'b111, 2'b00, 0, 0, 0, "R3");
      step(0, 0, 0, 3'b111, 0, 24'hffffff, "R3");
      step(0, 0, 0, 3'b111, 0, 0, "R10");
      step(0, 0, 0, 3'b111, 0, 0, "R10");
      chk(rel == 1, "R10", "held by go-read", rel, 1);
      step(0, 0, 0, 0, 0, 0, "R10");
      chk(rel == 0, "R10", "released", rel, 0);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 5) == 0, 3'($urandom), 2'($urandom), 3'($urandom),
              2'($urandom), 24'($urandom), "RND");
      end
      @(negedge clk);
      compare("END");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule